// File: doc/BRIEF.md
# Serial Port Sticky Status and Interrupt Source Selector

This block sits next to the transmit and receive datapath of a serial port. It keeps latched ("sticky") copies of three conditions: the transmit holding register is empty, the receive holding register is full, and the receive line is idle. The datapath drives it with event pulses and with live status levels. The live levels clear themselves when the datapath consumes or refills a register. A sticky copy stays set until software writes a zero to its bit.

A single mode bit chooses the source of the three interrupt requests. With the mode bit at 0, each request follows its live, self-clearing flag. With the mode bit at 1, each request follows its sticky copy. In both modes each request is gated by its own enable. Mode 1 allows a DMA engine to drain or fill the data registers without silently withdrawing a request. It also keeps a bus-idle request asserted until software acknowledges it, even after the line becomes busy again.

Top module: `usart_sticky_irq`

## Requirements
- R1: After reset, the read value is 4'b1000: the sticky transmit-empty flag is 1, the sticky receive-full flag is 0, the sticky idle flag is 0 and the mode bit is 0. All three interrupt outputs are 0.
- R2: A `tx_load` pulse sets the sticky transmit-empty flag (read bit 3) at the next clock edge. The flag stays set when `live_tx_empty` later drops.
- R3: An `rx_load` pulse sets the sticky receive-full flag (read bit 2) at the next clock edge. The flag stays set when `live_rx_full` later drops.
- R4: The sticky idle flag (read bit 1) is set at every clock edge where `bus_idle` is high. It stays set after `bus_idle` goes low.
- R5: A register write with a 0 in bit 3, 2 or 1 clears that sticky flag. A 1 in one of those bits leaves the flag unchanged. Without a write, no sticky flag ever falls.
- R6: If a set event and a write of 0 hit the same flag in the same cycle, the flag ends up set.
- R7: Read layout: bit 3 is sticky transmit-empty, bit 2 is sticky receive-full, bit 1 is sticky idle, bit 0 is the mode bit. Each write loads the mode bit from write bit 0.
- R8: With the mode bit at 0, each interrupt output at an edge is its enable ANDed with the live flag sampled at that edge. A cleared enable gives 0.
- R9: With the mode bit at 1, each interrupt output at an edge is its enable ANDed with the sticky flag as it stood before that edge. An interrupt therefore lags a flag or mode change by one cycle.
- R10: With the mode bit at 1, a bus-idle interrupt stays asserted after the line turns busy. It falls one cycle after software clears the sticky idle flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_load | input | 1 | Pulse: data moved into the transmit shift register |
| rx_load | input | 1 | Pulse: received data placed into the receive register |
| bus_idle | input | 1 | Live level: no reception activity on the line |
| live_tx_empty | input | 1 | Live self-clearing transmit-empty flag |
| live_rx_full | input | 1 | Live self-clearing receive-full flag |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| idle_ie | input | 1 | Bus-idle interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Register write value |
| rd_data | output | 4 | Register read value: flags and mode |
| tx_irq | output | 1 | Registered transmit interrupt request |
| rx_irq | output | 1 | Registered receive interrupt request |
| idle_irq | output | 1 | Registered bus-idle interrupt request |

## Verification
A hardware set event and a software clear can arrive in the same cycle on the same flag. The bench forces this directly: it raises `tx_load` together with a write that has bit 3 at zero, and expects the flag to read 1. A random phase then produces this collision on all three flags many times. A behavioural reference model judges every one of those cycles. The model also checks the one-cycle lag between a mode-bit write and the change of interrupt source.

// File: rtl/usart_sticky_irq.sv
module usart_sticky_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_load,
  input  logic       rx_load,
  input  logic       bus_idle,
  input  logic       live_tx_empty,
  input  logic       live_rx_full,
  input  logic       tx_ie,
  input  logic       rx_ie,
  input  logic       idle_ie,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic [3:0] rd_data,
  output logic       tx_irq,
  output logic       rx_irq,
  output logic       idle_irq
);

  logic hold_tx, hold_rx, hold_idle, use_sticky;
  logic clr_tx, clr_rx, clr_idle;

  assign clr_tx   = wr_en & ~wr_data[3];
  assign clr_rx   = wr_en & ~wr_data[2];
  assign clr_idle = wr_en & ~wr_data[1];

  // set events dominate a same-cycle software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_tx    <= 1'b1;
      hold_rx    <= 1'b0;
      hold_idle  <= 1'b0;
      use_sticky <= 1'b0;
    end else begin
      hold_tx   <= tx_load  | (hold_tx   & ~clr_tx);
      hold_rx   <= rx_load  | (hold_rx   & ~clr_rx);
      hold_idle <= bus_idle | (hold_idle & ~clr_idle);
      if (wr_en) use_sticky <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_irq   <= 1'b0;
      rx_irq   <= 1'b0;
      idle_irq <= 1'b0;
    end else begin
      tx_irq   <= tx_ie   & (use_sticky ? hold_tx   : live_tx_empty);
      rx_irq   <= rx_ie   & (use_sticky ? hold_rx   : live_rx_full);
      idle_irq <= idle_ie & (use_sticky ? hold_idle : bus_idle);
    end
  end

  assign rd_data = {hold_tx, hold_rx, hold_idle, use_sticky};

endmodule

// File: rtl/usart_sticky_irq_chk.sv
module usart_sticky_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_load,
  input logic       rx_load,
  input logic       bus_idle,
  input logic       live_tx_empty,
  input logic       live_rx_full,
  input logic       tx_ie,
  input logic       rx_ie,
  input logic       idle_ie,
  input logic       wr_en,
  input logic [3:0] wr_data,
  input logic [3:0] rd_data,
  input logic       tx_irq,
  input logic       rx_irq,
  input logic       idle_irq
);

  AST_TX_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n) tx_load |=> rd_data[3]); // R2
  AST_RX_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n) rx_load |=> rd_data[2]); // R3
  AST_IDLE_SETS: assert property (@(posedge clk) disable iff (!rst_n) bus_idle |=> rd_data[1]); // R4
  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((rd_data[3:1] & $past(rd_data[3:1])) == $past(rd_data[3:1]))); // R5
  AST_CLEAR_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[2] && !rx_load) |=> !rd_data[2]); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[3] && tx_load) |=> rd_data[3]); // R6
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[0] == $past(wr_data[0]))); // R7
  AST_LIVE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[0] && rx_ie && live_rx_full) |=> rx_irq); // R8
  AST_TX_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !tx_ie |=> !tx_irq); // R8
  AST_STICKY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && idle_ie && rd_data[1]) |=> idle_irq); // R10

endmodule

bind usart_sticky_irq usart_sticky_irq_chk u_chk (.*);

// File: tb/sim_usart_sticky_irq.sv
`timescale 1ns/1ps
module sim_usart_sticky_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_load = 0, rx_load = 0, bus_idle = 0;
  logic live_tx_empty = 0, live_rx_full = 0;
  logic tx_ie = 0, rx_ie = 0, idle_ie = 0;
  logic wr_en = 0;
  logic [3:0] wr_data = 4'h0;
  logic [3:0] rd_data;
  logic tx_irq, rx_irq, idle_irq;

  int checks = 0;
  int fails = 0;
  bit compare_on = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usart_sticky_irq u0 (.*);

  // behavioural reference model
  bit m_tx = 1, m_rx = 0, m_idle = 0, m_mode = 0;
  bit m_txi = 0, m_rxi = 0, m_idi = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx = 1; m_rx = 0; m_idle = 0; m_mode = 0;
      m_txi = 0; m_rxi = 0; m_idi = 0;
    end else begin
      if (m_mode) begin
        m_txi = tx_ie && m_tx;
        m_rxi = rx_ie && m_rx;
        m_idi = idle_ie && m_idle;
      end else begin
        m_txi = tx_ie && live_tx_empty;
        m_rxi = rx_ie && live_rx_full;
        m_idi = idle_ie && bus_idle;
      end
      if (wr_en) begin
        if (!wr_data[3]) m_tx = 0;
        if (!wr_data[2]) m_rx = 0;
        if (!wr_data[1]) m_idle = 0;
        m_mode = wr_data[0];
      end
      if (tx_load) m_tx = 1;
      if (rx_load) m_rx = 1;
      if (bus_idle) m_idle = 1;
    end
  end

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && !done) begin
      chk("R7 read value", {3'b0, rd_data}, {3'b0, m_tx, m_rx, m_idle, m_mode});
      chk("R8 or R9 interrupts", {4'b0, tx_irq, rx_irq, idle_irq}, {4'b0, m_txi, m_rxi, m_idi});
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] v);
    wr_en = 1; wr_data = v;
    tick();
    wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R1 reset read", {3'b0, rd_data}, 7'b0001000);
    chk("R1 reset irqs", {4'b0, tx_irq, rx_irq, idle_irq}, 7'b0);
    rst_n = 1;
    tick();
    chk("R1 after release", {3'b0, rd_data}, 7'b0001000);
    compare_on = 1;

    // R8: live source in mode 0
    tx_ie = 1; live_tx_empty = 1;
    tick();
    chk("R8 tx irq from live", {6'b0, tx_irq}, 7'd1);
    live_tx_empty = 0;
    tick();
    chk("R8 tx irq drops with live", {6'b0, tx_irq}, 7'd0);

    // R5: clear transmit flag
    wr(4'b0110);
    chk("R5 clear by zero", {3'b0, rd_data}, 7'b0000000);

    // R2: load sets, live drop does not clear
    tx_load = 1; tick(); tx_load = 0;
    chk("R2 tx_load sets", {6'b0, rd_data[3]}, 7'd1);
    tick();
    chk("R2 stays set", {6'b0, rd_data[3]}, 7'd1);

    // R6: set beats clear
    tx_load = 1; wr(4'b0110); tx_load = 0;
    chk("R6 set wins", {6'b0, rd_data[3]}, 7'd1);

    // R3
    rx_load = 1; live_rx_full = 1; tick();
    rx_load = 0; live_rx_full = 0; tick();
    chk("R3 rx sticky holds", {6'b0, rd_data[2]}, 7'd1);

    // R4
    bus_idle = 1; tick();
    bus_idle = 0; tick();
    chk("R4 idle sticky holds", {6'b0, rd_data[1]}, 7'd1);

    // R5: writing ones keeps flags
    wr(4'b1110);
    chk("R5 ones keep flags", {3'b0, rd_data}, 7'b0001110);

    // R7 / R9: switch to sticky source
    rx_ie = 1;
    wr(4'b1111);
    chk("R7 mode bit readable", {3'b0, rd_data}, 7'b0001111);
    chk("R9 source lags mode", {6'b0, rx_irq}, 7'd0);
    tick();
    chk("R9 rx irq from sticky", {6'b0, rx_irq}, 7'd1);
    chk("R9 tx irq from sticky", {6'b0, tx_irq}, 7'd1);

    // R10: idle irq survives a busy line until cleared
    idle_ie = 1;
    tick();
    chk("R10 idle irq asserted", {6'b0, idle_irq}, 7'd1);
    tick(3);
    chk("R10 idle irq held", {6'b0, idle_irq}, 7'd1);
    wr(4'b1101);
    chk("R10 flag cleared", {6'b0, rd_data[1]}, 7'd0);
    chk("R10 irq lags clear", {6'b0, idle_irq}, 7'd1);
    tick();
    chk("R10 irq drops", {6'b0, idle_irq}, 7'd0);

    // random phase, judged by the reference model every cycle (R6 collisions included)
    for (int i = 0; i < 3000; i++) begin
      tx_load = ($urandom % 4) == 0;
      rx_load = ($urandom % 4) == 0;
      bus_idle = ($urandom % 3) == 0;
      live_tx_empty = $urandom % 2;
      live_rx_full = $urandom % 2;
      tx_ie = ($urandom % 4) != 0;
      rx_ie = ($urandom % 4) != 0;
      idle_ie = ($urandom % 4) != 0;
      wr_en = ($urandom % 5) == 0;
      wr_data = 4'($urandom);
      tick();
    end
    wr_en = 0;
    tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule